// File: doc/BRIEF.md
# Burst-Mode Line Framing Sequencer

This block frames time-compression-multiplexed full-duplex traffic on one wire pair. Each direction sends short bursts in turn. A burst is a start symbol followed by 36 payload bits, which carry two frames of B1 (8 bits), B2 (8 bits) and D (2 bits). Symbols use alternate mark inversion: a one is sent as a mark whose polarity is opposite to the previous mark, and a zero is sent as the zero level. The start symbol is always a mark and is never scrambled. Its polarity continues the alternation from the last mark of the burst before it.

In the master role, a slot timer sends one burst per slot. An external sync pulse can restart the slot. In the slave role, the block decodes the received burst, closes its receiver, counts a guard time and then sends its reply. In the slave wake-up mode, the block instead sends on its own slot timer, but only in every second slot. The receiver is gated off while the block transmits. Scrambling is applied as an external XOR key stream in each direction.

The payload enters through a valid/ready port that holds one word. `tx_ready` is high while the holding register is empty. A burst that starts with the register empty sends all zeros. Received words leave through a valid/ready port. A word is held until it is accepted. A burst that completes while a word is still waiting is discarded.

Top module: `tcm_burst_seq`

## Requirements
- R1: While `rst_n` is low and after reset, `line_tx` is 2'b00, `rx_valid` is 0, `tx_ready` is 1, `rx_gate` is 1 and `bpv` is 0.
- R2: A burst is 37 symbols, one per `sym_en` tick: the start symbol, then payload bits 0 to 35 in that order. Each payload bit sent is the data bit XOR `tx_key`, sampled at that tick. The tick after the last payload bit drives 2'b00.
- R3: Line symbols are encoded as 2'b01 = +1, 2'b11 = -1 and 2'b00 = 0, and `line_tx` never shows 2'b10. Every mark, including the start symbol, has the opposite polarity to the previous mark sent. The first start symbol after reset is +1.
- R4: In the master role, a burst starts every `SLOT_SYMS` ticks. A tick with `burst_sync` high starts a burst at that tick and restarts the slot count, so the next burst follows `SLOT_SYMS` ticks later.
- R5: `rx_gate` is low whenever the block is transmitting. Symbols on `line_rx` while the gate is low produce no received word.
- R6: With the gate open, a nonzero `line_rx` symbol is taken as a start symbol. The next 36 ticks are decoded as bits, where any mark is 1, and each bit is XORed with `rx_key`. The word is presented on `rx_data`, bit 0 first received, with `rx_valid` high after the edge of the 36th bit.
- R7: In the slave role (`role_slave`=1, `wake_mode`=0), the gate closes after the 36th received bit. Six zero symbols follow, and the reply start symbol is driven at the seventh tick after the last received bit.
- R8: In the slave role with `wake_mode`=1, bursts come from the slot timer but only in every second slot. This gives a period of 2*`SLOT_SYMS` ticks.
- R9: `bpv` pulses for one cycle when a received payload mark has the same polarity as the previous mark in the same burst. The polarity of the start symbol against the previous burst is not checked.
- R10: `rx_valid` and `rx_data` hold until `rx_ready`. A burst that completes while an earlier word is still waiting is discarded.
- R11: A `tx_valid`/`tx_ready` handshake fills a one-word holding register, and `tx_ready` stays low until a burst start takes the word. A burst that starts with the register empty sends zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | Symbol-rate tick |
| role_slave | input | 1 | 1 = slave role, 0 = master role |
| wake_mode | input | 1 | Slave wake-up mode: send on alternate slots |
| burst_sync | input | 1 | Master slot restart, sampled on ticks |
| tx_data | input | PAYLOAD_BITS | Payload word to send |
| tx_valid | input | 1 | Payload word offered |
| tx_ready | output | 1 | Holding register empty |
| tx_key | input | 1 | Transmit scrambler key bit |
| line_tx | output | 2 | Ternary line output |
| line_rx | input | 2 | Ternary line input |
| rx_key | input | 1 | Receive descrambler key bit |
| rx_gate | output | 1 | Receiver enabled |
| rx_data | output | PAYLOAD_BITS | Received payload word |
| rx_valid | output | 1 | Received word waiting |
| rx_ready | input | 1 | Consumer takes received word |
| bpv | output | 1 | Bipolar violation pulse |

## Verification
On every cycle, the assertions check that marks keep alternating across burst boundaries, that the unused line code never appears, and that the receiver is closed whenever a mark leaves the block. They also check that a waiting received word stays frozen and that a full holding register refuses new data. Only the bench scenarios can show the cycle positions: the slot period, the sync restart, the six-symbol guard before a slave reply and the alternate-slot spacing in wake-up mode. The bench scenarios also show the payload bit order, the key XOR, the exclusion of the start polarity from violation checks and the discarding of a burst that arrives while a word is waiting.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int PAYLOAD_DEFAULT = 36;

  typedef logic [1:0] sym_t;
  localparam sym_t SYM_ZERO = 2'b00;
  localparam sym_t SYM_POS  = 2'b01;
  localparam sym_t SYM_NEG  = 2'b11;

  typedef enum logic [1:0] {
    SEQ_RX    = 2'd0,
    SEQ_GUARD = 2'd1,
    SEQ_SEND  = 2'd2
  } seq_state_t;

  function automatic sym_t mark_of(input logic negative);
    return negative ? SYM_NEG : SYM_POS;
  endfunction

  function automatic logic is_mark(input sym_t s);
    return (s == SYM_POS) || (s == SYM_NEG);
  endfunction
endpackage

// File: rtl/tcm_slot_timer.sv
module tcm_slot_timer #(
  parameter int SLOT_SYMS = 512,
  localparam int CW = $clog2(SLOT_SYMS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_en,
  input  logic sync_ok,
  input  logic alt_only,
  output logic slot_fire
);
  logic [CW-1:0] cnt;
  logic          skip_next;
  logic          wrap;

  assign wrap      = sym_en && (sync_ok || cnt == CW'(SLOT_SYMS - 1));
  assign slot_fire = wrap && !(alt_only && skip_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      skip_next <= 1'b0;
    end else if (wrap) begin
      cnt       <= '0;
      skip_next <= ~skip_next;
    end else if (sym_en) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tcm_ami_tx.sv
module tcm_ami_tx
  import tcm_pkg::*;
#(
  parameter int N = 36,
  localparam int CW = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sym_en,
  input  logic         start,
  input  logic [N-1:0] payload,
  input  logic         key,
  output logic [1:0]   line,
  output logic         last_tick
);
  logic [N-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          last_neg;
  logic          bit_out;

  assign bit_out   = shreg[0] ^ key;
  assign last_tick = busy && (cnt == CW'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      last_neg <= 1'b1;
      line     <= SYM_ZERO;
    end else if (sym_en) begin
      if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        shreg    <= payload;
        line     <= mark_of(~last_neg);
        last_neg <= ~last_neg;
      end else if (busy) begin
        if (cnt == CW'(N)) begin
          busy <= 1'b0;
          line <= SYM_ZERO;
        end else begin
          cnt   <= cnt + 1'b1;
          shreg <= shreg >> 1;
          if (bit_out) begin
            line     <= mark_of(~last_neg);
            last_neg <= ~last_neg;
          end else begin
            line <= SYM_ZERO;
          end
        end
      end else begin
        line <= SYM_ZERO;
      end
    end
  end
endmodule

// File: rtl/tcm_ami_rx.sv
module tcm_ami_rx
  import tcm_pkg::*;
#(
  parameter int N = 36,
  localparam int CW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sym_en,
  input  logic         enable,
  input  logic [1:0]   line,
  input  logic         key,
  output logic [N-1:0] word_next,
  output logic         word_done,
  output logic         bpv
);
  logic [N-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          collecting;
  logic          last_neg;
  logic          mark;
  logic          neg;

  assign mark      = is_mark(line);
  assign neg       = (line == SYM_NEG);
  assign word_next = {mark ^ key, shreg[N-1:1]};
  assign word_done = sym_en && enable && collecting && (cnt == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      collecting <= 1'b0;
      last_neg   <= 1'b0;
      bpv        <= 1'b0;
    end else begin
      bpv <= 1'b0;
      if (!enable) begin
        collecting <= 1'b0;
      end else if (sym_en) begin
        if (!collecting) begin
          if (mark) begin
            collecting <= 1'b1;
            cnt        <= '0;
            last_neg   <= neg;
          end
        end else begin
          shreg <= word_next;
          cnt   <= cnt + 1'b1;
          if (mark) begin
            last_neg <= neg;
            bpv      <= (neg == last_neg);
          end
          if (cnt == CW'(N - 1)) collecting <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tcm_burst_seq.sv
module tcm_burst_seq
  import tcm_pkg::*;
#(
  parameter int PAYLOAD_BITS = 36,
  parameter int SLOT_SYMS    = 512,
  parameter int GUARD_SYMS   = 6,
  localparam int GW = $clog2(GUARD_SYMS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_en,
  input  logic                    role_slave,
  input  logic                    wake_mode,
  input  logic                    burst_sync,
  input  logic [PAYLOAD_BITS-1:0] tx_data,
  input  logic                    tx_valid,
  output logic                    tx_ready,
  input  logic                    tx_key,
  output logic [1:0]              line_tx,
  input  logic [1:0]              line_rx,
  input  logic                    rx_key,
  output logic                    rx_gate,
  output logic [PAYLOAD_BITS-1:0] rx_data,
  output logic                    rx_valid,
  input  logic                    rx_ready,
  output logic                    bpv
);
  seq_state_t              state;
  logic [GW-1:0]           gcnt;
  logic                    slot_fire;
  logic                    tx_start;
  logic                    tx_last;
  logic                    turn_go;
  logic                    slot_go;
  logic                    hold_full;
  logic [PAYLOAD_BITS-1:0] hold_data;
  logic [PAYLOAD_BITS-1:0] word_next;
  logic                    word_done;
  logic                    tx_accept;
  logic                    turnaround_mode;

  assign turnaround_mode = role_slave && !wake_mode;
  assign slot_go   = slot_fire && !turnaround_mode;
  assign turn_go   = (state == SEQ_GUARD) && sym_en && (gcnt == GW'(GUARD_SYMS));
  assign tx_start  = slot_go || turn_go;
  assign rx_gate   = (state == SEQ_RX);
  assign tx_ready  = !hold_full;
  assign tx_accept = tx_valid && tx_ready;

  tcm_slot_timer #(.SLOT_SYMS(SLOT_SYMS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_en   (sym_en),
    .sync_ok  (burst_sync && !role_slave),
    .alt_only (role_slave && wake_mode),
    .slot_fire(slot_fire)
  );

  tcm_ami_tx #(.N(PAYLOAD_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_en   (sym_en),
    .start    (tx_start),
    .payload  (hold_full ? hold_data : '0),
    .key      (tx_key),
    .line     (line_tx),
    .last_tick(tx_last)
  );

  tcm_ami_rx #(.N(PAYLOAD_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_en   (sym_en),
    .enable   (rx_gate),
    .line     (line_rx),
    .key      (rx_key),
    .word_next(word_next),
    .word_done(word_done),
    .bpv      (bpv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_RX;
      gcnt  <= '0;
    end else if (tx_start) begin
      state <= SEQ_SEND;
      gcnt  <= '0;
    end else begin
      case (state)
        SEQ_RX:    if (word_done && turnaround_mode) begin
                     state <= SEQ_GUARD;
                     gcnt  <= '0;
                   end
        SEQ_GUARD: if (sym_en) gcnt <= gcnt + 1'b1;
        SEQ_SEND:  if (sym_en && tx_last) state <= SEQ_RX;
        default:   state <= SEQ_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (tx_accept) hold_data <= tx_data;
      if (tx_start)       hold_full <= tx_accept;
      else if (tx_accept) hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (word_done && (!rx_valid || rx_ready)) begin
        rx_valid <= 1'b1;
        rx_data  <= word_next;
      end
    end
  end
endmodule

// File: rtl/tcm_burst_seq_chk.sv
module tcm_burst_seq_chk #(
  parameter int PAYLOAD_BITS = 36
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sym_en,
  input logic [1:0]              line_tx,
  input logic                    rx_gate,
  input logic [PAYLOAD_BITS-1:0] rx_data,
  input logic                    rx_valid,
  input logic                    rx_ready,
  input logic                    tx_valid,
  input logic                    tx_ready,
  input logic                    bpv
);
  logic tick_q;
  logic seen_mark;
  logic prev_neg;
  logic new_mark;

  assign new_mark = tick_q && (line_tx != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q    <= 1'b0;
      seen_mark <= 1'b0;
      prev_neg  <= 1'b0;
    end else begin
      tick_q <= sym_en;
      if (new_mark) begin
        seen_mark <= 1'b1;
        prev_neg  <= (line_tx == 2'b11);
      end
    end
  end

  // R3
  line_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_tx != 2'b10);

  // R3
  mark_alternation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_mark && seen_mark) |-> ((line_tx == 2'b11) != prev_neg));

  // R5
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tx != 2'b00) |-> !rx_gate);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R9
  bpv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bpv |-> $past(rx_gate));
endmodule

bind tcm_burst_seq tcm_burst_seq_chk #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sym_en  (sym_en),
  .line_tx (line_tx),
  .rx_gate (rx_gate),
  .rx_data (rx_data),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .bpv     (bpv)
);

// File: tb/tcm_burst_seq_bench.sv
module tcm_burst_seq_bench;
  localparam int NB   = 36;
  localparam int SLOT = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sym_en;
  logic          role_slave;
  logic          wake_mode;
  logic          burst_sync;
  logic [NB-1:0] tx_data;
  logic          tx_valid;
  logic          tx_ready;
  logic          tx_key;
  logic [1:0]    line_tx;
  logic [1:0]    line_rx;
  logic          rx_key;
  logic          rx_gate;
  logic [NB-1:0] rx_data;
  logic          rx_valid;
  logic          rx_ready;
  logic          bpv;

  int checks = 0;
  int errors = 0;
  int m_pol;
  int r_pol;

  tcm_burst_seq #(.PAYLOAD_BITS(NB), .SLOT_SYMS(SLOT), .GUARD_SYMS(6)) u_tcm_burst_seq (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .role_slave(role_slave),
    .wake_mode(wake_mode), .burst_sync(burst_sync), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_key(tx_key),
    .line_tx(line_tx), .line_rx(line_rx), .rx_key(rx_key), .rx_gate(rx_gate),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .bpv(bpv)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] enc(int p);
    return (p > 0) ? 2'b01 : 2'b11;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit slave, bit wake);
    rst_n = 1'b0; sym_en = 1'b1; role_slave = slave; wake_mode = wake;
    burst_sync = 1'b0; tx_data = '0; tx_valid = 1'b0; tx_key = 1'b0;
    line_rx = 2'b00; rx_key = 1'b0; rx_ready = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    m_pol = -1;
    r_pol = -1;
  endtask

  task automatic load_tx(logic [NB-1:0] d);
    tx_data = d; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
  endtask

  // Current sample shows the start symbol; checks 36 payload symbols and the tail.
  task automatic expect_burst(logic [NB-1:0] d, bit key, string req);
    logic [1:0] e;
    m_pol = -m_pol;
    e = enc(m_pol);
    chk(line_tx == e, req, "start symbol", line_tx, e);
    for (int i = 0; i < NB; i++) begin
      step();
      if (d[i] ^ key) begin
        m_pol = -m_pol;
        e = enc(m_pol);
      end else begin
        e = 2'b00;
      end
      chk(line_tx == e, req, $sformatf("payload symbol %0d", i), line_tx, e);
    end
    step();
    chk(line_tx == 2'b00, "R2", "tail symbol", line_tx, 2'b00);
  endtask

  task automatic send_burst(logic [NB-1:0] d, bit same_start, int viol, output int nbpv);
    int p;
    nbpv = 0;
    r_pol = same_start ? r_pol : -r_pol;
    line_rx = enc(r_pol);
    step();
    for (int i = 0; i < NB; i++) begin
      if (d[i]) begin
        p = (i == viol) ? r_pol : -r_pol;
        r_pol = p;
        line_rx = enc(p);
      end else begin
        line_rx = 2'b00;
      end
      step();
      if (bpv) nbpv++;
    end
    line_rx = 2'b00;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk(line_tx == 2'b00, "R1", "line_tx", line_tx, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
    chk(rx_gate == 1'b1, "R1", "rx_gate", rx_gate, 1);
    chk(bpv == 1'b0, "R1", "bpv", bpv, 0);
  endtask

  task automatic t_master_tx();
    do_reset(1'b0, 1'b0);
    load_tx(36'h9_A5C3_1E7B);
    chk(tx_ready == 1'b0, "R11", "tx_ready after load", tx_ready, 0);
    burst_sync = 1'b1;
    step();
    burst_sync = 1'b0;
    chk(rx_gate == 1'b0, "R5", "gate during send", rx_gate, 0);
    expect_burst(36'h9_A5C3_1E7B, 1'b0, "R2");
    chk(tx_ready == 1'b1, "R11", "tx_ready after start", tx_ready, 1);
    chk(rx_gate == 1'b1, "R5", "gate after send", rx_gate, 1);
    repeat (SLOT - 1 - 37) step();
    chk(line_tx == 2'b00, "R4", "no burst before slot end", line_tx, 0);
    step();
    chk(line_tx != 2'b00, "R4", "burst at slot period", line_tx, 1);
    expect_burst('0, 1'b0, "R11");
    load_tx(36'h3_0F0F_00FF);
    tx_key = 1'b1;
    burst_sync = 1'b1;
    step();
    burst_sync = 1'b0;
    expect_burst(36'h3_0F0F_00FF, 1'b1, "R2");
    tx_key = 1'b0;
  endtask

  task automatic t_master_rx();
    int nb;
    do_reset(1'b0, 1'b0);
    burst_sync = 1'b1;
    step();
    burst_sync = 1'b0;
    line_rx = 2'b01;
    expect_burst('0, 1'b0, "R3");
    line_rx = 2'b00;
    chk(rx_valid == 1'b0, "R5", "no word from gated input", rx_valid, 0);
    repeat (3) step();
    chk(rx_valid == 1'b0, "R5", "still no word", rx_valid, 0);
    rx_key = 1'b1;
    send_burst(36'h5_1234_ABCD, 1'b0, -1, nb);
    rx_key = 1'b0;
    chk(rx_valid == 1'b1, "R6", "rx_valid", rx_valid, 1);
    chk(rx_data == (36'h5_1234_ABCD ^ {NB{1'b1}}), "R6", "rx_data with key",
        rx_data, 36'h5_1234_ABCD ^ {NB{1'b1}});
  endtask

  task automatic t_slave();
    int nb;
    do_reset(1'b1, 1'b0);
    load_tx(36'hC_3C3C_5A5A);
    send_burst(36'h7_7E01_8242, 1'b0, -1, nb);
    chk(rx_valid == 1'b1, "R6", "slave rx_valid", rx_valid, 1);
    chk(rx_data == 36'h7_7E01_8242, "R6", "slave rx_data", rx_data, 36'h7_7E01_8242);
    chk(rx_gate == 1'b0, "R7", "gate closed in guard", rx_gate, 0);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(line_tx == 2'b00, "R7", $sformatf("guard symbol %0d", i), line_tx, 0);
    end
    step();
    expect_burst(36'hC_3C3C_5A5A, 1'b0, "R7");
    send_burst(36'h0_F00F_0110, 1'b1, -1, nb);
    chk(nb == 0, "R9", "start polarity not checked", nb, 0);
    chk(rx_data == 36'h0_F00F_0110, "R6", "second word", rx_data, 36'h0_F00F_0110);
    repeat (44) step();
    send_burst(36'h0_0000_00F3, 1'b0, 1, nb);
    chk(nb == 1, "R9", "violation pulses", nb, 1);
  endtask

  task automatic t_backpressure();
    int nb;
    do_reset(1'b0, 1'b0);
    rx_ready = 1'b0;
    send_burst(36'h1_1111_2222, 1'b0, -1, nb);
    chk(rx_valid == 1'b1, "R10", "first word valid", rx_valid, 1);
    send_burst(36'h2_3333_4444, 1'b0, -1, nb);
    chk(rx_data == 36'h1_1111_2222, "R10", "held word kept", rx_data, 36'h1_1111_2222);
    rx_ready = 1'b1;
    step();
    chk(rx_valid == 1'b0, "R10", "valid drops after accept", rx_valid, 0);
  endtask

  task automatic t_wake();
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 4 * SLOT && line_tx == 2'b00; i++) step();
    chk(line_tx != 2'b00, "R8", "first wake burst", line_tx, 1);
    repeat (SLOT) step();
    chk(line_tx == 2'b00, "R8", "alternate slot skipped", line_tx, 0);
    repeat (SLOT) step();
    chk(line_tx != 2'b00, "R8", "burst two slots later", line_tx, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_master_tx();
    t_master_rx();
    t_slave();
    t_backpressure();
    t_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule